// File: doc/BRIEF.md
# Streaming Bitmap-Group Set Intersection Tree

This block intersects eight sorted sets while they stream in. Every set travels as a sequence of words. A word is a group number in the upper field and a membership bitmap in the lower field. Element value `v` lands in group `v / BMP_W`, at bit `v % BMP_W`. Within one batch the words of every stream carry strictly increasing group numbers. The batch is closed by a marker word whose group field is all ones.

Two-input merge cells do the reduction. Each cell compares the group numbers at its two heads. It discards the word with the lower group and advances only that input. When the groups are equal it forwards the group with the AND of both bitmaps and advances both inputs. A merged bitmap of zero is not forwarded. The marker carries the highest possible group number, so a stream that has reached its marker holds still. The other stream then runs out its remaining words until it reaches its own marker. At that point both markers are consumed together and a single marker leaves the cell.

Seven cells form a balanced tree, and the tree has a valid/ready handshake on every input and on the result. The root delivers the intersection of all eight sets for each batch, followed by one marker, and moves on to the next batch without a gap.

Top module: `setx_tree`

## Requirements
- R1: A word is `{gid[GID_W-1:0], bmp[BMP_W-1:0]}` with gid in the upper bits. Element value v is encoded as gid = v / BMP_W with bit v % BMP_W of bmp set. With defaults (10, 32) values 0 to 32735 are representable.
- R2: While reset is asserted and after it is released with no input, `out_valid` is 0.
- R3: When both heads of a cell carry the same data gid, the cell emits that gid with the AND of the two bitmaps and consumes both heads in the same cycle.
- R4: When the head gids differ, only the word with the smaller gid is consumed and nothing is emitted for it. Sets with no common gid yield no data words.
- R5: A data word whose ANDed bitmap is zero is not emitted.
- R6: Gid all ones (1023 by default) marks end of batch. Its input bitmap is ignored. Words of one stream that remain when the other stream has reached its marker are discarded. Exactly one marker word, with bitmap 0, is emitted per batch, and back-to-back batches never mix. An empty set is a stream holding only the marker.
- R7: For each batch, the output is every gid whose AND over all eight input bitmaps is nonzero, in ascending gid order, with that AND as bitmap, then the marker.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` stays unchanged. No word is lost or duplicated under backpressure or input gaps.
- R9: With all inputs valid and matching and `out_ready` held at 1, the tree accepts one word per input and emits one word per clock. A word consumed at the inputs appears at the output exactly 3 cycles later (one register per tree level).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | N_IN | Per-stream word valid |
| in_data | input | N_IN*(GID_W+BMP_W) | Per-stream word, stream k at bits [k*W +: W] |
| in_ready | output | N_IN | Per-stream word consumed this cycle |
| out_valid | output | 1 | Result word valid |
| out_data | output | GID_W+BMP_W | Result word |
| out_ready | input | 1 | Downstream accepts the result word |

## Verification
The tree holds no state except the pipeline word in each cell. A wrong state therefore shows at the root within three cycles, in one of four forms: a result word that differs from the reference intersection, a word that appears twice, a word that goes missing, or a marker that arrives too early or too late. Any of these breaks the in-order comparison of the output against the expected queue on the very handshake where it occurs. A cell that steps the wrong input, or that fails to throw away a stream's tail at the marker, leaves stale words in a later batch. The empty-set and back-to-back batch sequences catch this as soon as the next marker arrives. A held word that changes under backpressure is caught in the next cycle.

// File: rtl/setx_pkg.sv
package setx_pkg;
   localparam int SETX_GID_W = 10;
   localparam int SETX_BMP_W = 32;
   localparam int SETX_N_IN  = 8;

   typedef enum logic [1:0] {
      ACT_IDLE,
      ACT_DROP_A,
      ACT_DROP_B,
      ACT_MATCH
   } setx_act_e;
endpackage

// File: rtl/setx_decide.sv
module setx_decide
   import setx_pkg::*;
#(
   parameter int GID_W      = SETX_GID_W,
   parameter int BMP_W      = SETX_BMP_W,
   parameter bit DROP_EMPTY = 1'b1
) (
   input  logic                     a_valid,
   input  logic [GID_W+BMP_W-1:0]   a_word,
   input  logic                     b_valid,
   input  logic [GID_W+BMP_W-1:0]   b_word,
   input  logic                     advance,
   output logic                     take_a,
   output logic                     take_b,
   output logic                     emit,
   output logic [GID_W+BMP_W-1:0]   res_word
);
   localparam logic [GID_W-1:0] MARK = {GID_W{1'b1}};

   logic [GID_W-1:0] gid_a, gid_b;
   logic [BMP_W-1:0] anded;
   logic             at_mark, keep;
   setx_act_e        act;

   assign gid_a   = a_word[GID_W+BMP_W-1:BMP_W];
   assign gid_b   = b_word[GID_W+BMP_W-1:BMP_W];
   assign anded   = a_word[BMP_W-1:0] & b_word[BMP_W-1:0];
   assign at_mark = (gid_a == MARK);

   always_comb begin
      act = ACT_IDLE;
      if (a_valid && b_valid && advance) begin
         if (gid_a < gid_b)      act = ACT_DROP_A;
         else if (gid_b < gid_a) act = ACT_DROP_B;
         else                    act = ACT_MATCH;
      end
   end

   generate
      if (DROP_EMPTY) begin : g_drop_empty
         assign keep = at_mark || (|anded);
      end else begin : g_keep_all
         assign keep = 1'b1;
      end
   endgenerate

   assign take_a   = (act == ACT_DROP_A) || (act == ACT_MATCH);
   assign take_b   = (act == ACT_DROP_B) || (act == ACT_MATCH);
   assign emit     = (act == ACT_MATCH) && keep;
   assign res_word = at_mark ? {MARK, {BMP_W{1'b0}}} : {gid_a, anded};
endmodule

// File: rtl/setx_pe.sv
module setx_pe
   import setx_pkg::*;
#(
   parameter int GID_W      = SETX_GID_W,
   parameter int BMP_W      = SETX_BMP_W,
   parameter bit DROP_EMPTY = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     a_valid,
   input  logic [GID_W+BMP_W-1:0]   a_data,
   output logic                     a_ready,
   input  logic                     b_valid,
   input  logic [GID_W+BMP_W-1:0]   b_data,
   output logic                     b_ready,
   output logic                     o_valid,
   output logic [GID_W+BMP_W-1:0]   o_data,
   input  logic                     o_ready
);
   localparam int                WORD_W = GID_W + BMP_W;
   localparam logic [GID_W-1:0]  MARK   = {GID_W{1'b1}};

   logic              advance, emit;
   logic [WORD_W-1:0] res_word;

   assign advance = !o_valid || o_ready;

   setx_decide #(
      .GID_W      (GID_W),
      .BMP_W      (BMP_W),
      .DROP_EMPTY (DROP_EMPTY)
   ) i_decide (
      .a_valid  (a_valid),
      .a_word   (a_data),
      .b_valid  (b_valid),
      .b_word   (b_data),
      .advance  (advance),
      .take_a   (a_ready),
      .take_b   (b_ready),
      .emit     (emit),
      .res_word (res_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         o_valid <= 1'b0;
         o_data  <= '0;
      end else if (advance) begin
         o_valid <= emit;
         if (emit) o_data <= res_word;
      end
   end

   // R8
   hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      o_valid && !o_ready |=> o_valid && $stable(o_data));

   // R3
   pair_gid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      a_ready && b_ready |-> a_data[WORD_W-1:BMP_W] == b_data[WORD_W-1:BMP_W]);

   // R4
   drop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      a_ready && !b_ready |-> a_data[WORD_W-1:BMP_W] < b_data[WORD_W-1:BMP_W]);

   // R6
   mark_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      o_valid && o_data[WORD_W-1:BMP_W] == MARK |-> o_data[BMP_W-1:0] == '0);

   // R9
   keep_moving_chk: assert property (@(posedge clk) disable iff (!rst_n)
      a_valid && b_valid && o_ready |-> a_ready || b_ready);

   generate
      if (DROP_EMPTY) begin : g_nz_chk
         // R5
         nonzero_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
            o_valid && o_data[WORD_W-1:BMP_W] != MARK |-> o_data[BMP_W-1:0] != '0);
      end
   endgenerate
endmodule

// File: rtl/setx_tree.sv
module setx_tree
   import setx_pkg::*;
#(
   parameter int N_IN       = SETX_N_IN,
   parameter int GID_W      = SETX_GID_W,
   parameter int BMP_W      = SETX_BMP_W,
   parameter bit DROP_EMPTY = 1'b1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [N_IN-1:0]                in_valid,
   input  logic [N_IN*(GID_W+BMP_W)-1:0]  in_data,
   output logic [N_IN-1:0]                in_ready,
   output logic                           out_valid,
   output logic [GID_W+BMP_W-1:0]         out_data,
   input  logic                           out_ready
);
   localparam int WORD_W  = GID_W + BMP_W;
   localparam int N_NODE  = 2 * N_IN - 1;
   localparam int LEAF0   = N_IN - 1;

   generate
      if (N_IN < 2 || (N_IN & (N_IN - 1)) != 0) begin : g_bad_n
         $error("setx_tree: N_IN must be a power of two, at least 2");
      end
      if (GID_W < 2 || BMP_W < 1) begin : g_bad_w
         $error("setx_tree: GID_W must be at least 2 and BMP_W at least 1");
      end
   endgenerate

   logic [N_NODE-1:0] nd_valid, nd_ready;
   logic [WORD_W-1:0] nd_data [N_NODE];

   genvar k;
   generate
      for (k = 0; k < N_IN; k++) begin : g_leaf
         assign nd_valid[LEAF0+k] = in_valid[k];
         assign nd_data[LEAF0+k]  = in_data[k*WORD_W +: WORD_W];
         assign in_ready[k]       = nd_ready[LEAF0+k];
      end
      for (k = 0; k < N_IN - 1; k++) begin : g_cell
         setx_pe #(
            .GID_W      (GID_W),
            .BMP_W      (BMP_W),
            .DROP_EMPTY (DROP_EMPTY)
         ) i_pe (
            .clk     (clk),
            .rst_n   (rst_n),
            .a_valid (nd_valid[2*k+1]),
            .a_data  (nd_data[2*k+1]),
            .a_ready (nd_ready[2*k+1]),
            .b_valid (nd_valid[2*k+2]),
            .b_data  (nd_data[2*k+2]),
            .b_ready (nd_ready[2*k+2]),
            .o_valid (nd_valid[k]),
            .o_data  (nd_data[k]),
            .o_ready (nd_ready[k])
         );
      end
   endgenerate

   assign out_valid   = nd_valid[0];
   assign out_data    = nd_data[0];
   assign nd_ready[0] = out_ready;
endmodule

// File: tb/test_setx_tree.sv
module test_setx_tree;
   localparam int N  = 8;
   localparam int GW = 10;
   localparam int BW = 32;
   localparam int WW = GW + BW;
   localparam int NG = 1023;
   localparam logic [GW-1:0] MARK = '1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N-1:0]    in_valid = '0;
   logic [N*WW-1:0] in_data = '0;
   logic [N-1:0]    in_ready;
   logic            out_valid;
   logic [WW-1:0]   out_data;
   logic            out_ready = 1'b0;

   always #10 clk = ~clk;

   setx_tree i_setx_tree (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
      .out_ready(out_ready)
   );

   int nchk = 0, nfail = 0, cyc = 0;
   logic [WW-1:0] inq [N][$];
   logic [WW-1:0] expq [$];
   string         expt [$];
   logic [BW-1:0] bm [N][NG];
   bit gaps = 0, bp = 0, meas = 0, hold_pend = 0, done = 0;
   logic [WW-1:0] held;
   int first_in = -1;
   int outcyc [$];
   string curtag = "R7";

   task automatic check(bit ok, string tag, logic [WW-1:0] got, logic [WW-1:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // per-cycle driver, reference queues and output comparison
   initial begin
      forever begin
         @(negedge clk);
         cyc++;
         for (int i = 0; i < N; i++) begin
            in_valid[i] = inq[i].size() > 0 && !(gaps && ($urandom % 4 == 0));
            in_data[i*WW +: WW] = in_valid[i] ? inq[i][0] : '0;
         end
         out_ready = !(bp && ($urandom % 3 == 0));
         #5;
         if (rst_n) begin
            for (int i = 0; i < N; i++)
               if (in_valid[i] && in_ready[i]) begin
                  void'(inq[i].pop_front());
                  if (meas && first_in < 0) first_in = cyc;
               end
            if (hold_pend) check(out_valid && out_data == held, "R8", out_data, held);
            if (out_valid && out_ready) begin
               if (meas) outcyc.push_back(cyc);
               if (expq.size() == 0) check(1'b0, curtag, out_data, '0);
               else begin
                  logic [WW-1:0] e;
                  string t;
                  e = expq.pop_front();
                  t = expt.pop_front();
                  check(out_data == e, t, out_data, e);
               end
            end
            hold_pend = out_valid && !out_ready;
            held = out_data;
         end
      end
   end

   task automatic clr();
      for (int i = 0; i < N; i++)
         for (int g = 0; g < NG; g++) bm[i][g] = '0;
   endtask

   task automatic load(string tag);
      for (int i = 0; i < N; i++) begin
         for (int g = 0; g < NG; g++)
            if (bm[i][g] != '0) inq[i].push_back({g[GW-1:0], bm[i][g]});
         inq[i].push_back({MARK, $urandom()});   // marker bitmap ignored (R6)
      end
      for (int g = 0; g < NG; g++) begin
         logic [BW-1:0] a;
         a = '1;
         for (int i = 0; i < N; i++) a &= bm[i][g];
         if (a != '0) begin
            expq.push_back({g[GW-1:0], a});
            expt.push_back(tag);
         end
      end
      expq.push_back({MARK, {BW{1'b0}}});
      expt.push_back("R6");
   endtask

   task automatic drain(string tag);
      int t;
      bit busy;
      t = 0;
      curtag = tag;
      do begin
         @(negedge clk);
         t++;
         busy = expq.size() > 0;
         for (int i = 0; i < N; i++) if (inq[i].size() > 0) busy = 1;
      end while (busy && t < 5000);
      repeat (6) @(negedge clk);
      check(!busy && expq.size() == 0, tag, WW'(expq.size()), '0);
   endtask

   task automatic add_val(int i, int v);
      bm[i][v / BW][v % BW] = 1'b1;   // R1 encoding
   endtask

   initial begin
      #(20 * 150000);
      check(1'b0, "watchdog", '0, '0);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #5 check(out_valid == 1'b0, "R2", WW'(out_valid), '0);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      #5 check(out_valid == 1'b0, "R2", WW'(out_valid), '0);

      // R1: element values encoded into gid/bit
      clr();
      for (int i = 0; i < N; i++) begin
         add_val(i, 5); add_val(i, 37); add_val(i, 100); add_val(i, 32735);
         add_val(i, 7 + i * 40);
      end
      load("R1");
      drain("R1");

      // R3: identical sets everywhere
      clr();
      for (int g = 0; g < 64; g++) begin
         logic [BW-1:0] r;
         r = ($urandom % 3 == 0) ? '0 : $urandom();
         for (int i = 0; i < N; i++) bm[i][g] = r;
      end
      load("R3");
      drain("R3");

      // R4: two inputs with no common gid
      clr();
      for (int g = 0; g < 64; g++)
         for (int i = 0; i < N; i++)
            bm[i][g] = (i == 0 && g % 2 == 1) || (i == 1 && g % 2 == 0) ? '0 : '1;
      load("R4");
      drain("R4");

      // R5: common gids, disjoint bits
      clr();
      for (int g = 0; g < 32; g++)
         for (int i = 0; i < N; i++)
            bm[i][g] = (i == 0) ? 32'h0000_FFFF : (i == 1) ? 32'hFFFF_0000 : '1;
      load("R5");
      drain("R5");

      // R6: empty set on one input, then a second batch queued behind it
      clr();
      for (int g = 0; g < 40; g++)
         for (int i = 0; i < N; i++) bm[i][g] = (i == 3) ? '0 : $urandom() | 32'h1;
      load("R6");
      clr();
      for (int g = 0; g < 40; g += 3)
         for (int i = 0; i < N; i++) bm[i][g] = 32'h8000_0001 | $urandom();
      load("R6");
      drain("R6");

      // R7 and R8: random sets with input gaps and output backpressure
      gaps = 1; bp = 1;
      for (int b = 0; b < 6; b++) begin
         logic [BW-1:0] com;
         clr();
         for (int g = 0; g < 64; g++) begin
            com = $urandom() & $urandom();
            for (int i = 0; i < N; i++)
               bm[i][g] = ($urandom % 10 == 0) ? '0 : (com | ($urandom() & $urandom()));
         end
         load("R7");
      end
      drain("R7");
      gaps = 0; bp = 0;

      // R9: dense identical streams, full rate
      clr();
      for (int g = 0; g < 20; g++)
         for (int i = 0; i < N; i++) bm[i][g] = 32'h0F0F_0000 | g;
      repeat (2) @(negedge clk);
      meas = 1; first_in = -1; outcyc.delete();
      load("R9");
      drain("R9");
      meas = 0;
      check(outcyc.size() == 21, "R9", WW'(outcyc.size()), WW'(21));
      if (outcyc.size() > 0)
         check(outcyc[0] - first_in == 3, "R9", WW'(outcyc[0] - first_in), WW'(3));
      for (int k = 1; k < outcyc.size(); k++)
         check(outcyc[k] == outcyc[0] + k, "R9", WW'(outcyc[k]), WW'(outcyc[0] + k));

      done = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end
endmodule